// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counting timer. Software reaches it through a small register port with four addresses: the live count, a period value, a control byte and an interrupt byte. When the timer runs, a prescaler divides the clock, and each prescaled tick moves the count up by one. When the count already equals the period on a tick, the count goes back to zero and a match event occurs.

Each match event gives a one-cycle pulse on `shiftTick`, which a serial port can use as a shift-clock source. The match events also feed a postscaler that divides them by 1 to 16. Each postscaled event sets a sticky interrupt flag. The flag combined with its enable bit drives `irqPending`.

A bus write to the count or to the control byte clears the hidden prescale and postscale counters. A write to the control byte leaves the count unchanged.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0, the period reads 8'hFF, the control byte reads 0, and the interrupt flag and interrupt enable read 0.
- R2: The register map is address 0 count, 1 period, 2 control, 3 interrupt byte (bit 0 flag, bit 1 enable, other bits read 0). In the control byte, bit 7 reads 0, bits 6:3 are the postscale select, bit 2 is the run enable and bits 1:0 are the prescale select.
- R3: Prescale select 00 gives one tick per clock, 01 one tick per 4 clocks and 1x one tick per 16 clocks. The count changes on a tick only.
- R4: On a tick where the count equals the period, the count becomes 0 instead of incrementing. `shiftTick` is high for exactly the one cycle that follows that clock edge.
- R5: With postscale select N, the interrupt flag is set once every N+1 match events, at the same edge as the match that completes the group.
- R6: A bus write to the count loads the written value and clears the hidden prescale and postscale counters.
- R7: A bus write to the control byte clears the hidden prescale and postscale counters and leaves the count unchanged.
- R8: Software clears the flag by writing 0 to bit 0 of the interrupt byte. A hardware set in the same cycle wins.
- R9: `irqPending` is high exactly when both the flag and the interrupt enable are 1.
- R10: While the run enable is 0, the count and the hidden counters hold their values.
- R11: A bus write to the count or to the control byte takes priority over a tick in the same cycle: no increment and no match occur in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset (covers every reset source) |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr` (combinational) |
| shiftTick | output | 1 | Unscaled match pulse for the serial shift clock |
| irqFlag | output | 1 | Sticky match interrupt flag |
| irqPending | output | 1 | Flag qualified by the interrupt enable |

## Verification
A write or tick at one clock edge is visible right after that edge. The count, period, control byte, flag and `shiftTick` all change on that same edge. `busRdata` follows `busAddr` with no delay. The bench updates a reference model at each rising edge and compares all outputs 3 ns later, before the inputs are driven again at the falling edge. Every comparison therefore checks the state produced by the edge just passed. The directed reads drive the address at a falling edge and sample 1 ns later, with no clock edge in between.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 2;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_IRQ    = 2'd3;

  typedef struct packed {
    logic             cntLoad;
    logic             perLoad;
    logic             tick;
    logic [CNT_W-1:0] data;
  } dp_strobe_t;
endpackage

// File: rtl/pt_datapath.sv
module pt_datapath
  import pt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] periodQ,
  output logic             hit
);
  // The compare uses the current count and period.
  assign hit = (countQ == periodQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.cntLoad) begin
      countQ <= strobe.data;
    end else if (strobe.tick) begin
      countQ <= hit ? '0 : countQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= '1;
    end else if (strobe.perLoad) begin
      periodQ <= strobe.data;
    end
  end
endmodule

// File: rtl/pt_control.sv
module pt_control
  import pt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic              hit,
  output dp_strobe_t        strobe,
  output logic [1:0]        presSel,
  output logic              runEn,
  output logic [POST_W-1:0] postSel,
  output logic              flagQ,
  output logic              irqEnQ,
  output logic              shiftQ
);
  logic             wrCount, wrPeriod, wrCtrl, wrIrq, clrHidden;
  logic [PRE_W-1:0] presCnt, presTerm;
  logic [POST_W-1:0] postCnt;
  logic             presWrap, tick, matchEv, postFire;

  assign wrCount   = busWe && (busAddr == ADDR_COUNT);
  assign wrPeriod  = busWe && (busAddr == ADDR_PERIOD);
  assign wrCtrl    = busWe && (busAddr == ADDR_CTRL);
  assign wrIrq     = busWe && (busAddr == ADDR_IRQ);
  assign clrHidden = wrCount || wrCtrl;

  // Terminal value of the prescaler for the selected divide ratio.
  always_comb begin
    unique case (presSel)
      2'b00:   presTerm = PRE_W'(0);
      2'b01:   presTerm = PRE_W'(3);
      default: presTerm = PRE_W'(15);
    endcase
  end

  assign presWrap = runEn && (presCnt == presTerm);
  assign tick     = presWrap && !clrHidden;
  assign matchEv  = tick && hit;
  assign postFire = matchEv && (postCnt == postSel);

  always_comb begin
    strobe.cntLoad = wrCount;
    strobe.perLoad = wrPeriod;
    strobe.tick    = tick;
    strobe.data    = busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
    end else if (clrHidden) begin
      presCnt <= '0;
    end else if (runEn) begin
      presCnt <= (presCnt == presTerm) ? '0 : presCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postCnt <= '0;
    end else if (clrHidden) begin
      postCnt <= '0;
    end else if (matchEv) begin
      postCnt <= (postCnt == postSel) ? '0 : postCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presSel <= '0;
      runEn   <= 1'b0;
      postSel <= '0;
    end else if (wrCtrl) begin
      presSel <= busWdata[1:0];
      runEn   <= busWdata[2];
      postSel <= busWdata[3 +: POST_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      irqEnQ <= 1'b0;
      shiftQ <= 1'b0;
    end else begin
      flagQ  <= postFire || (wrIrq ? busWdata[0] : flagQ);
      irqEnQ <= wrIrq ? busWdata[1] : irqEnQ;
      shiftQ <= matchEv;
    end
  end
endmodule

// File: rtl/period_timer.sv
module period_timer
  import pt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              shiftTick,
  output logic              irqFlag,
  output logic              irqPending
);
  dp_strobe_t        strobe;
  logic [CNT_W-1:0]  countQ, periodQ;
  logic              hit, runEn, flagQ, irqEnQ, shiftQ;
  logic [1:0]        presSel;
  logic [POST_W-1:0] postSel;

  pt_control ctrl_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .hit(hit), .strobe(strobe), .presSel(presSel),
    .runEn(runEn), .postSel(postSel), .flagQ(flagQ), .irqEnQ(irqEnQ),
    .shiftQ(shiftQ)
  );

  pt_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .countQ(countQ),
    .periodQ(periodQ), .hit(hit)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_COUNT:  busRdata = countQ;
      ADDR_PERIOD: busRdata = periodQ;
      ADDR_CTRL:   busRdata = {1'b0, postSel, runEn, presSel};
      default:     busRdata = {6'b0, irqEnQ, flagQ};
    endcase
  end

  assign shiftTick  = shiftQ;
  assign irqFlag    = flagQ;
  assign irqPending = flagQ && irqEnQ;
endmodule

// File: rtl/pt_checker.sv
module pt_checker
  import pt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0]  busWdata,
  input logic [CNT_W-1:0]  countQ,
  input logic [CNT_W-1:0]  periodQ,
  input logic              runEn,
  input logic [1:0]        presSel,
  input logic              shiftTick
);
  // R4: the count is zero in the cycle that the match pulse is high.
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    shiftTick |-> countQ == '0);

  // R4: with a divider above 1 the match pulse lasts one cycle.
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (shiftTick && presSel != 2'b00) |=> !shiftTick);

  // R6: a count write loads the written value.
  a_r6_count_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_COUNT) |=> countQ == $past(busWdata));

  // R7: a control write leaves the count unchanged.
  a_r7_ctrl_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_CTRL) |=> countQ == $past(countQ));

  // R10: with the timer stopped and no write, the count holds.
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !busWe) |=> $stable(countQ));

  // R1: the period register leaves reset at all ones.
  a_r1_period_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> periodQ == '1);
endmodule

bind period_timer pt_checker chk_i (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .busWdata(busWdata), .countQ(countQ), .periodQ(periodQ), .runEn(runEn),
  .presSel(presSel), .shiftTick(shiftTick)
);

// File: tb/period_timer_tb.sv
module period_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       shiftTick, irqFlag, irqPending;

  int errors = 0;
  int checks = 0;
  bit live = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  period_timer dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .shiftTick(shiftTick),
    .irqFlag(irqFlag), .irqPending(irqPending)
  );

  // Reference state, derived from the requirements.
  logic [7:0] mCnt, mPer;
  logic [6:0] mCtl;
  logic [3:0] mPre, mPost;
  logic       mFlag, mEn, mShift;

  function automatic logic [3:0] divTerm(input logic [1:0] sel); // R3
    return (sel == 2'b00) ? 4'd0 : (sel == 2'b01) ? 4'd3 : 4'd15;
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a); // R2
    case (a)
      2'd0:    return mCnt;
      2'd1:    return mPer;
      2'd2:    return {1'b0, mCtl};
      default: return {6'b0, mEn, mFlag};
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; mPer <= 8'hFF; mCtl <= 0; mPre <= 0; mPost <= 0;
      mFlag <= 0; mEn <= 0; mShift <= 0;
    end else begin
      logic wrC, wrP, wrK, wrI, clr, tk, mv, pf;
      logic [3:0] term;
      wrC = busWe && busAddr == 2'd0;
      wrP = busWe && busAddr == 2'd1;
      wrK = busWe && busAddr == 2'd2;
      wrI = busWe && busAddr == 2'd3;
      clr = wrC || wrK;                             // R6 R7
      term = divTerm(mCtl[1:0]);
      tk = mCtl[2] && mPre == term && !clr;         // R3 R10 R11
      mv = tk && mCnt == mPer;                      // R4
      pf = mv && mPost == mCtl[6:3];                // R5
      if (clr) mPre <= 0;
      else if (mCtl[2]) mPre <= (mPre == term) ? 4'd0 : mPre + 4'd1;
      if (clr) mPost <= 0;
      else if (mv) mPost <= (mPost == mCtl[6:3]) ? 4'd0 : mPost + 4'd1;
      if (wrC) mCnt <= busWdata;
      else if (tk) mCnt <= mv ? 8'd0 : mCnt + 8'd1;
      if (wrP) mPer <= busWdata;
      if (wrK) mCtl <= busWdata[6:0];
      mFlag <= pf || (wrI ? busWdata[0] : mFlag);   // R8
      if (wrI) mEn <= busWdata[1];
      mShift <= mv;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Compare all outputs 3 ns after each rising edge.
  always begin
    @(posedge clk);
    #3;
    if (live && rstN) begin
      check("R4 shiftTick", {7'b0, shiftTick}, {7'b0, mShift});
      check("R5 irqFlag", {7'b0, irqFlag}, {7'b0, mFlag});
      check("R9 irqPending", {7'b0, irqPending}, {7'b0, mFlag && mEn});
      check("R2 busRdata", busRdata, expRead(busAddr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #1 check(req, busRdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(2'd0, 8'h00, "R1 count reset");
    rd(2'd1, 8'hFF, "R1 period reset");
    rd(2'd2, 8'h00, "R1 control reset");
    rd(2'd3, 8'h00, "R1 irq byte reset");
    // R2: bit 7 of control reads 0
    wr(2'd2, 8'hFB);
    rd(2'd2, 8'h7B, "R2 control bit7");
    // R7: control write keeps count; R10 frozen while stopped
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h05);
    repeat (5) @(negedge clk);
    rd(2'd0, 8'h05, "R10 frozen count");
    wr(2'd2, 8'h01);
    rd(2'd0, 8'h05, "R7 count kept");
    // R11: count write beats a same-cycle tick at divide-by-1
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h20);
    #1 check("R11 write priority", busRdata, 8'h20);
    // R8: set wins over software clear (period 0, /1, postscale 1:1)
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    repeat (2) @(negedge clk);
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h01, "R8 set wins");
    // R5: postscale 1:3, period 2, divide-by-4
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h00);
    live = 1'b1;
    wr(2'd2, 8'h15);
    repeat (120) @(negedge clk);
    // Random mixture, checked each cycle against the model.
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      busAddr = 2'($urandom % 4);
      busWe = ($urandom % 12) == 0;
      case (busAddr)
        2'd0, 2'd1: busWdata = 8'($urandom % 8);
        2'd2:       busWdata = 8'($urandom) | (($urandom % 4 != 0) ? 8'h04 : 8'h00);
        default:    busWdata = 8'($urandom);
      endcase
    end
    @(negedge clk);
    busWe = 1'b0;
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule